// File: doc/BRIEF.md
# Counter Clock and Gate Source Selector

This block sits in front of several groups of three-channel counter/timers and chooses what each channel counts and what gates it. Each group holds two counters of three channels each. A host writes one byte to a group's clock-select register, or one byte to its gate-select register. That byte names the counter of the pair, the channel and a 5-bit source number. The block keeps the chosen source for every channel.

Every cycle, the block drives a count-enable strobe and a gate level to each counter channel. Clock source 0 is the channel's own external clock pin. The pin is synchronized, and each rising edge becomes a one-cycle strobe. Sources 1 to 5 are decade timebases derived from a 20 MHz master clock: 10 MHz, 1 MHz, 100 kHz, 10 kHz and 1 kHz. Source 11 is the full master rate and is allowed only in enhanced mode. Gate source 0 holds the gate high.

Any other source number gives a constant 0, so the counter does not advance. A debug port reads back the stored sources of any channel.

Top module: `ctr_src_select`

## Requirements
- R1: Clock-select registers sit at byte addresses 0x18+g and gate-select registers at 0x1B+g, for group g = 0..2. A write to any other address changes no stored source.
- R2: In the written byte, bit 5 picks the counter of the pair, bits 4:3 the channel, and {bits 7:6, bits 2:0} the source. The flat channel index is g*6 + pair*3 + channel. A write whose channel field is 3 is ignored.
- R3: While `enh_en` is 0, a write whose source exceeds 7 is ignored. While `enh_en` is 1, sources 0 to 31 are stored.
- R4: Clock sources 1 to 5 give one-cycle count enables at one master cycle in 2, 20, 200, 2000 and 20000. Clock source 11 enables every cycle while `enh_en` is 1.
- R5: With clock source 0, each rising edge of `ext_clk[i]` gives exactly one `cnt_en[i]` pulse, two cycles after the pin is first sampled high.
- R6: Gate source 0 drives the gate level to 1 and any other gate source drives it to 0. A clock source that has no function gives `cnt_en` 0; these are 6 to 10, 12 to 31, and 11 while `enh_en` is 0.
- R7: Reset sets every stored source to 0, every `cnt_en` to 0, every `gate_lvl` to 1 and the debug outputs to 0.
- R8: The outputs are registered. A write latched at clock edge k first affects `cnt_en` and `gate_lvl` at edge k+1. The debug outputs show the sources of `dbg_idx` one cycle after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock (20 MHz assumed) |
| rst | input | 1 | Synchronous active-high reset |
| enh_en | input | 1 | Enhanced mode: 5-bit sources and source 11 allowed |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register byte address |
| wr_data | input | 8 | Register write byte |
| ext_clk | input | 18 | External clock pin per channel (asynchronous) |
| dbg_idx | input | 5 | Channel index for source readback |
| cnt_en | output | 18 | Count-enable strobe per channel |
| gate_lvl | output | 18 | Gate level per channel |
| dbg_clk_src | output | 5 | Stored clock source of channel dbg_idx |
| dbg_gate_src | output | 5 | Stored gate source of channel dbg_idx |

## Verification
A cycle-accurate reference model in the bench predicts every output on every clock. The stimulus is chosen to tell apart the ways the selector could go wrong:
- Pulse counts over fixed windows for the 10 MHz, 1 MHz, 100 kHz and 1 kHz sources catch a prescaler ratio that is off by one, or a strobe routed to the wrong timebase.
- A burst of edges on one external pin checks that each rising edge gives exactly one strobe.
- Writes to neighbouring addresses, a channel field of 3, and a 5-bit source written in basic mode each test the write filter. Their effect is read back through the debug port.
- Turning enhanced mode off while source 11 is selected checks that the fast source stops.

// File: rtl/ctrsel_pkg.sv
package ctrsel_pkg;
  localparam int SRC_W = 5;
  typedef logic [SRC_W-1:0] src_t;

  localparam src_t SRC_EXT       = 5'd0;
  localparam src_t SRC_FAST      = 5'd11;
  localparam src_t SRC_BASIC_MAX = 5'd7;

  // Layout of a select byte; the field positions are fixed by the host.
  typedef struct packed {
    logic [1:0] hi;
    logic       pair;
    logic [1:0] chan;
    logic [2:0] lo;
  } sel_byte_t;

  function automatic src_t byte_src(sel_byte_t b);
    return {b.hi, b.lo};
  endfunction

  // True when a clock source selects nothing that can count.
  function automatic logic src_dead(src_t s, logic enh, int n_stages);
    logic live;
    live = (s == SRC_EXT) || (int'(s) >= 1 && int'(s) <= n_stages) ||
           (s == SRC_FAST && enh);
    return !live;
  endfunction
endpackage

// File: rtl/ctrsel_timebase.sv
module ctrsel_timebase #(
  parameter int DIV_FIRST = 2,
  parameter int DECADE    = 10,
  parameter int N_STAGES  = 5
) (
  input  logic                clk,
  input  logic                rst,
  output logic [N_STAGES-1:0] tick
);
  localparam int MAXDIV = (DIV_FIRST > DECADE) ? DIV_FIRST : DECADE;
  localparam int CW     = $clog2(MAXDIV + 1);

  for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
    localparam int LIM = (k == 0) ? DIV_FIRST : DECADE;
    logic [CW-1:0] cnt;
    logic          adv;

    if (k == 0) begin : g_head
      assign adv = 1'b1;
    end else begin : g_link
      assign adv = tick[k-1];
    end

    assign tick[k] = adv && (cnt == CW'(LIM - 1));

    always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (adv) cnt <= tick[k] ? '0 : cnt + 1'b1;
    end

    if (LIM > 1) begin : g_chk
      // R4: a divided timebase is never high two cycles in a row
      p_tick_sparse_r4: assert property (@(posedge clk) disable iff (rst)
        tick[k] |=> !tick[k]);
    end
  end
endmodule

// File: rtl/ctrsel_pin_sync.sv
module ctrsel_pin_sync #(
  parameter int N = 18
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] pin,
  output logic [N-1:0] rise
);
  logic [N-1:0] m1, m2, m3;

  always_ff @(posedge clk) begin
    if (rst) begin
      m1 <= '0;
      m2 <= '0;
      m3 <= '0;
    end else begin
      m1 <= pin;
      m2 <= m1;
      m3 <= m2;
    end
  end

  assign rise = m2 & ~m3;

  // R5: an edge yields a single-cycle pulse
  p_rise_once_r5: assert property (@(posedge clk) disable iff (rst)
    (rise & $past(rise)) == '0);
endmodule

// File: rtl/ctrsel_regs.sv
module ctrsel_regs
  import ctrsel_pkg::*;
#(
  parameter int NUM_GROUPS = 3,
  parameter int CPC        = 3,
  parameter int CLK_BASE   = 'h18,
  parameter int NCH        = NUM_GROUPS * 2 * CPC,
  parameter int IDX_W      = $clog2(NCH)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      enh_en,
  input  logic                      wr_en,
  input  logic [7:0]                wr_addr,
  input  logic [7:0]                wr_data,
  input  logic [IDX_W-1:0]          dbg_idx,
  output logic [NCH-1:0][SRC_W-1:0] clk_src,
  output logic [NCH-1:0][SRC_W-1:0] gate_src,
  output src_t                      dbg_clk_src,
  output src_t                      dbg_gate_src
);
  localparam int GATE_BASE = CLK_BASE + NUM_GROUPS;

  sel_byte_t        b;
  int               a, grp, flat;
  logic             hit_clk, hit_gate, accept;
  logic [IDX_W-1:0] flat_idx;

  assign b = sel_byte_t'(wr_data);

  always_comb begin
    a        = int'(wr_addr);
    hit_clk  = (a >= CLK_BASE) && (a < CLK_BASE + NUM_GROUPS);
    hit_gate = (a >= GATE_BASE) && (a < GATE_BASE + NUM_GROUPS);
    grp      = hit_clk ? (a - CLK_BASE) : (a - GATE_BASE);
    flat     = grp * 2 * CPC + int'(b.pair) * CPC + int'(b.chan);
    flat_idx = IDX_W'(flat);
    accept   = wr_en && (hit_clk || hit_gate) && (int'(b.chan) < CPC) &&
               (enh_en || (byte_src(b) <= SRC_BASIC_MAX));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_src  <= '0;
      gate_src <= '0;
    end else if (accept) begin
      if (hit_clk) clk_src[flat_idx]  <= byte_src(b);
      else         gate_src[flat_idx] <= byte_src(b);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dbg_clk_src  <= '0;
      dbg_gate_src <= '0;
    end else if (int'(dbg_idx) < NCH) begin
      dbg_clk_src  <= clk_src[dbg_idx];
      dbg_gate_src <= gate_src[dbg_idx];
    end else begin
      dbg_clk_src  <= '0;
      dbg_gate_src <= '0;
    end
  end

  // R3: wide sources are dropped in basic mode
  p_basic_reject_r3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !enh_en && b.hi != 2'b00) |=> ($stable(clk_src) && $stable(gate_src)));

  // R1: writes outside the register window leave all sources alone
  p_addr_window_r1: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !hit_clk && !hit_gate) |=> ($stable(clk_src) && $stable(gate_src)));
endmodule

// File: rtl/ctr_src_select.sv
module ctr_src_select
  import ctrsel_pkg::*;
#(
  parameter  int NUM_GROUPS = 3,
  parameter  int CH_PER_CTR = 3,
  parameter  int CLK_BASE   = 'h18,
  parameter  int DIV_FIRST  = 2,
  parameter  int DECADE     = 10,
  parameter  int N_STAGES   = 5,
  localparam int NCH        = NUM_GROUPS * 2 * CH_PER_CTR,
  localparam int IDX_W      = $clog2(NCH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enh_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_addr,
  input  logic [7:0]       wr_data,
  input  logic [NCH-1:0]   ext_clk,
  input  logic [IDX_W-1:0] dbg_idx,
  output logic [NCH-1:0]   cnt_en,
  output logic [NCH-1:0]   gate_lvl,
  output logic [4:0]       dbg_clk_src,
  output logic [4:0]       dbg_gate_src
);
  logic [NCH-1:0][SRC_W-1:0] clk_src, gate_src;
  logic [N_STAGES-1:0]       tick;
  logic [NCH-1:0]            rise, en_nxt, gate_nxt;

  ctrsel_regs #(
    .NUM_GROUPS(NUM_GROUPS), .CPC(CH_PER_CTR), .CLK_BASE(CLK_BASE),
    .NCH(NCH), .IDX_W(IDX_W)
  ) u_regs (
    .clk(clk), .rst(rst), .enh_en(enh_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .dbg_idx(dbg_idx),
    .clk_src(clk_src), .gate_src(gate_src),
    .dbg_clk_src(dbg_clk_src), .dbg_gate_src(dbg_gate_src)
  );

  ctrsel_timebase #(
    .DIV_FIRST(DIV_FIRST), .DECADE(DECADE), .N_STAGES(N_STAGES)
  ) u_tb (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ctrsel_pin_sync #(.N(NCH)) u_sync (
    .clk(clk), .rst(rst), .pin(ext_clk), .rise(rise)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic sel;

    always_comb begin
      sel = 1'b0;
      if (clk_src[i] == SRC_EXT)       sel = rise[i];
      else if (clk_src[i] == SRC_FAST) sel = enh_en;
      for (int k = 0; k < N_STAGES; k++)
        if (int'(clk_src[i]) == k + 1) sel = tick[k];
    end

    assign en_nxt[i]   = sel;
    assign gate_nxt[i] = (gate_src[i] == '0);

    // R6: gate level follows the stored gate source one cycle later
    p_gate_one_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(gate_src[i]) == '0) |-> gate_lvl[i]);
    p_gate_zero_r6: assert property (@(posedge clk) disable iff (rst)
      ($past(gate_src[i]) != '0) |-> !gate_lvl[i]);

    // R6: a dead clock source never enables counting
    p_dead_src_r6: assert property (@(posedge clk) disable iff (rst)
      $past(src_dead(clk_src[i], enh_en, N_STAGES)) |-> !cnt_en[i]);

    if (DIV_FIRST == 2) begin : g_fast
      // R4: the half-rate timebase alternates every cycle
      p_half_rate_r4: assert property (@(posedge clk) disable iff (rst)
        ($past(clk_src[i]) == 5'd1 && $past(clk_src[i], 2) == 5'd1) |->
        (cnt_en[i] != $past(cnt_en[i])));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_en   <= '0;
      gate_lvl <= '1;
    end else begin
      cnt_en   <= en_nxt;
      gate_lvl <= gate_nxt;
    end
  end

  // R7: outputs leave reset idle with every gate open
  p_reset_out_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (gate_lvl == '1 && cnt_en == '0));
endmodule

// File: tb/sim_ctr_src_select.sv
module sim_ctr_src_select;
  localparam int NCH = 18;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            enh_en = 1'b0;
  logic            wr_en = 1'b0;
  logic [7:0]      wr_addr = '0;
  logic [7:0]      wr_data = '0;
  logic [NCH-1:0]  ext_clk = '0;
  logic [4:0]      dbg_idx = '0;
  logic [NCH-1:0]  cnt_en, gate_lvl;
  logic [4:0]      dbg_clk_src, dbg_gate_src;

  int nchk = 0;
  int nfail = 0;
  bit run = 0;
  bit done = 0;

  always #10 clk = ~clk;

  ctr_src_select u0 (
    .clk(clk), .rst(rst), .enh_en(enh_en), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .ext_clk(ext_clk),
    .dbg_idx(dbg_idx), .cnt_en(cnt_en), .gate_lvl(gate_lvl),
    .dbg_clk_src(dbg_clk_src), .dbg_gate_src(dbg_gate_src)
  );

  // ---------------- reference model ----------------
  int         m_clk[NCH];
  int         m_gate[NCH];
  bit         q1[NCH], q2[NCH], q3[NCH];
  longint     elapsed;
  bit [NCH-1:0] x_en, x_gate;
  int         x_dc, x_dg;

  function automatic bit tb_strobe(int s, longint e, bit enh);
    longint p;
    if (s >= 1 && s <= 5) begin
      p = 2;
      for (int j = 1; j < s; j++) p = p * 10;
      return ((e + 1) % p) == 0;
    end
    if (s == 11) return enh;
    return 1'b0;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        m_clk[i] = 0; m_gate[i] = 0; q1[i] = 0; q2[i] = 0; q3[i] = 0;
      end
      elapsed = 0; x_en = '0; x_gate = '1; x_dc = 0; x_dg = 0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        x_en[i]   = (m_clk[i] == 0) ? (q2[i] && !q3[i]) : tb_strobe(m_clk[i], elapsed, enh_en);
        x_gate[i] = (m_gate[i] == 0);
      end
      x_dc = (dbg_idx < NCH) ? m_clk[dbg_idx] : 0;
      x_dg = (dbg_idx < NCH) ? m_gate[dbg_idx] : 0;
      for (int i = 0; i < NCH; i++) begin
        q3[i] = q2[i]; q2[i] = q1[i]; q1[i] = ext_clk[i];
      end
      elapsed++;
      if (wr_en) begin
        int a, pr, ch, s, idx;
        a  = int'(wr_addr);
        pr = int'(wr_data[5]);
        ch = int'(wr_data[4:3]);
        s  = int'(wr_data[7:6]) * 8 + int'(wr_data[2:0]);
        if (ch < 3 && (enh_en || s < 8)) begin
          if (a >= 'h18 && a < 'h1B) begin
            idx = (a - 'h18) * 6 + pr * 3 + ch; m_clk[idx] = s;
          end else if (a >= 'h1B && a < 'h1E) begin
            idx = (a - 'h1B) * 6 + pr * 3 + ch; m_gate[idx] = s;
          end
        end
      end
    end
  end

  task automatic chk(bit ok, string tag, longint act, longint exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (run && !rst) begin
      chk(cnt_en == x_en, "R4 R5 R6 R8 cnt_en vs model", cnt_en, x_en);
      chk(gate_lvl == x_gate, "R6 R8 gate_lvl vs model", gate_lvl, x_gate);
      chk(int'(dbg_clk_src) == x_dc, "R2 R8 dbg_clk_src vs model", dbg_clk_src, x_dc);
      chk(int'(dbg_gate_src) == x_dg, "R2 R8 dbg_gate_src vs model", dbg_gate_src, x_dg);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic peek(input int idx, input int ec, input int eg, input string tag);
    dbg_idx = 5'(idx);
    @(negedge clk);
    chk(int'(dbg_clk_src) == ec, tag, dbg_clk_src, ec);
    chk(int'(dbg_gate_src) == eg, tag, dbg_gate_src, eg);
  endtask

  task automatic tally(input int ch, input int n, inout int c);
    repeat (n) begin
      @(negedge clk);
      c += int'(cnt_en[ch]);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    int c;
    repeat (4) @(negedge clk);
    chk(cnt_en == '0, "R7 reset cnt_en", cnt_en, 0);
    chk(gate_lvl == '1, "R7 reset gate_lvl", gate_lvl, 18'h3FFFF);
    chk(dbg_clk_src == '0 && dbg_gate_src == '0, "R7 reset debug", dbg_clk_src, 0);
    rst = 1'b0;
    run = 1'b1;

    // R2: channel field 3 ignored; R1: out-of-window addresses ignored
    wr(8'h18, 8'h1C);
    wr(8'h1E, 8'h05);
    wr(8'h17, 8'h05);
    peek(3, 0, 0, "R2 channel 3 write ignored");
    peek(0, 0, 0, "R1 outside window ignored");

    // R2: field placement into flat index
    wr(8'h18, 8'h0A);
    wr(8'h18, 8'h17);
    wr(8'h18, 8'h21);
    wr(8'h18, 8'h2D);
    wr(8'h19, 8'h33);
    peek(1, 2, 0, "R2 idx1 src2");
    peek(2, 7, 0, "R2 idx2 src7");
    peek(3, 1, 0, "R2 idx3 src1");
    peek(4, 5, 0, "R2 idx4 src5");
    peek(11, 3, 0, "R2 idx11 src3");

    // R3: wide source rejected in basic mode, stored in enhanced mode
    wr(8'h1A, 8'h4B);
    peek(13, 0, 0, "R3 basic mode rejects 11");
    @(negedge clk) enh_en = 1'b1;
    wr(8'h1A, 8'h4B);
    peek(13, 11, 0, "R3 enhanced stores 11");
    c = 0; tally(13, 50, c);
    chk(c == 50, "R4 source 11 every cycle", c, 50);
    @(negedge clk) enh_en = 1'b0;
    @(negedge clk);
    c = 0; tally(13, 50, c);
    chk(c == 0, "R6 source 11 idle in basic mode", c, 0);

    // R4 / R6: timebase rates
    c = 0; tally(3, 100, c);
    chk(c == 50, "R4 10MHz rate", c, 50);
    c = 0; tally(1, 200, c);
    chk(c == 10, "R4 1MHz rate", c, 10);
    c = 0; tally(11, 400, c);
    chk(c == 2, "R4 100kHz rate", c, 2);
    c = 0; tally(2, 100, c);
    chk(c == 0, "R6 unimplemented source 7", c, 0);

    // R8 / R6: gate write latency and level
    wr(8'h1B, 8'h31);
    chk(gate_lvl[5] == 1'b1, "R8 gate unchanged one cycle after write", gate_lvl[5], 1);
    @(negedge clk);
    chk(gate_lvl[5] == 1'b0, "R8 R6 gate low after write", gate_lvl[5], 0);
    peek(5, 0, 1, "R2 gate idx5 src1");
    wr(8'h1C, 8'h02);
    @(negedge clk);
    chk(gate_lvl[6] == 1'b0, "R6 gate source 2 low", gate_lvl[6], 0);
    wr(8'h1C, 8'h00);
    @(negedge clk);
    chk(gate_lvl[6] == 1'b1, "R6 gate source 0 high", gate_lvl[6], 1);

    // R5: external pin edges
    c = 0;
    for (int n = 0; n < 5; n++) begin
      ext_clk[0] = 1'b1; tally(0, 4, c);
      ext_clk[0] = 1'b0; tally(0, 4, c);
    end
    tally(0, 4, c);
    chk(c == 5, "R5 one strobe per pin edge", c, 5);

    // R4: slowest timebase
    c = 0; tally(4, 40000, c);
    chk(c == 2, "R4 1kHz rate", c, 2);

    done = 1'b1;
    finish_run();
  end

  initial begin
    #(20 * 150000);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      finish_run();
    end
  end
endmodule